// File: doc/BRIEF.md
# Phase-Shifted H-Bridge Gate Generator

This block drives the four switches of a full H-bridge from a single clock. A free-running counter sets the switching frequency. Each counter wrap flips the right leg. A second compare point inside the same count flips the left leg. The distance between the two flip points sets how long the diagonal switch pairs overlap, and that overlap is the effective load duty.

Every flip of a leg is break-before-make:
- the conducting switch is released first;
- a programmable number of clock cycles passes with both switches of the leg off;
- only then is the partner switch closed.

Both flip directions take the same number of cycles, so the two halves of each leg waveform match in width. The period, compare and dead-time inputs are sampled into working copies only at a counter wrap, or while the block is disabled. A running cycle is therefore never cut short.

Top module: `hbg_phase_gate`

## Requirements
- R1: While reset is asserted, and from the first clock edge at which `enable` is low, all four gate outputs are 0 and both legs return to their start state.
- R2: While enabled, the counter counts 0..P, where P is the working period. The right leg flips on the cycle the counter equals P. Each leg output therefore repeats every 2·(P+1) clock cycles.
- R3: On a period match, the right leg releases whichever of `gate_tr`/`gate_br` is on. Its partner turns on after the dead time. The first match after enable turns `gate_br` on.
- R4: On a compare match (counter equals the working compare value), the left leg flips in the same way using `gate_tl`/`gate_bl`. The first match after enable turns `gate_tl` on.
- R5: When the compare value equals the period, the legs flip on the same cycle. `gate_tl` then equals `gate_br`, and `gate_bl` equals `gate_tr`, on every cycle.
- R6: A compare value greater than the period behaves exactly as a compare value equal to the period.
- R7: The dead time is D clock cycles, during which both switches of the flipping leg are off. A dead-time input of 0 is treated as 1.
- R8: A leg output that turns on at the Dth edge after its event stays on for exactly P+1−D cycles, in both directions.
- R9: New period, compare and dead-time inputs take effect only at a counter wrap, or while `enable` is low.
- R10: The two switches of one leg are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run; low holds the counter at 0 and all gates off |
| period_in | input | CNT_W (12) | Period count P |
| compare_in | input | CNT_W (12) | Left-leg compare point, clamped to P |
| dead_in | input | DEAD_W (8) | Dead time in cycles, 0 treated as 1 |
| gate_tl | output | 1 | Left leg, top switch |
| gate_bl | output | 1 | Left leg, bottom switch |
| gate_tr | output | 1 | Right leg, top switch |
| gate_br | output | 1 | Right leg, bottom switch |

## Verification
The assertions check the following on every cycle:
- no leg ever has both switches on;
- every turn-on is preceded by a cycle in which the partner switch was off;
- disabling clears all gates on the next edge;
- the counter never exceeds its working period.

Other behaviours cannot be seen by a per-cycle property and only the bench's scenarios can show them:
- the exact flip cycles and the first-switch choice;
- equal half-widths;
- the measured output period;
- phase alignment at full load and with an oversized compare value;
- deferral of new settings to the wrap.

// File: rtl/hbg_pkg.sv
// hbg_pkg: shared types for the H-bridge gate generator.
// Assumes nothing beyond standard packed struct support.
package hbg_pkg;

    // Drive pair for one bridge leg: hi = top switch, lo = bottom switch.
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_drive_t;

    // Leg index used in the generate loop of the top module.
    localparam int LEG_RIGHT = 0;
    localparam int LEG_LEFT  = 1;
    localparam int NUM_LEGS  = 2;

endpackage

// File: rtl/hbg_timebase.sv
// hbg_timebase: free-running period counter with shadowed settings.
// Counts 0..per_q, wraps, and raises per_hit on the last count and
// cmp_hit when the count equals the clamped compare value. Settings are
// loaded while disabled and at each wrap only.
// Assumes period_in >= 1 for a meaningful waveform.
module hbg_timebase #(
    parameter int CNT_W  = 12,
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CNT_W-1:0]  period_in,
    input  logic [CNT_W-1:0]  compare_in,
    input  logic [DEAD_W-1:0] dead_in,
    output logic              per_hit,
    output logic              cmp_hit,
    output logic [DEAD_W-1:0] dead_q,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  per_q
);
    localparam logic [DEAD_W-1:0] DEAD_MIN = DEAD_W'(1);

    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  cmp_next;
    logic [DEAD_W-1:0] dead_next;
    logic              wrap;

    // Clamp the compare point to the period and the dead time to at least one.
    always_comb begin
        cmp_next  = (compare_in > period_in) ? period_in : compare_in;
        dead_next = (dead_in == '0) ? DEAD_MIN : dead_in;
    end

    assign wrap    = en && (cnt == per_q);
    assign per_hit = wrap;
    assign cmp_hit = en && (cnt == cmp_q);

    // Counter advance and shadow reload at wrap or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            per_q  <= '0;
            cmp_q  <= '0;
            dead_q <= DEAD_MIN;
        end else if (!en || wrap) begin
            cnt    <= '0;
            per_q  <= period_in;
            cmp_q  <= cmp_next;
            dead_q <= dead_next;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hbg_leg.sv
// hbg_leg: break-before-make sequencer for one bridge leg.
// On evt the conducting switch is released at once and the partner is
// closed dead cycles later; both directions take the same path.
// FIRST_TOP picks which switch the first event after start closes.
// Assumes events are spaced further apart than the dead time.
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int DEAD_W    = 8,
    parameter bit FIRST_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              evt,
    input  logic [DEAD_W-1:0] dead,
    output leg_drive_t        drive
);
    localparam logic [DEAD_W-1:0] ONE = DEAD_W'(1);

    logic              sel_top;
    logic [DEAD_W-1:0] dcnt;

    // Leg state: selected side, dead-time countdown and registered drive.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sel_top  <= ~FIRST_TOP;
            dcnt     <= '0;
            drive.hi <= 1'b0;
            drive.lo <= 1'b0;
        end else if (evt) begin
            sel_top  <= ~sel_top;
            dcnt     <= dead;
            drive.hi <= 1'b0;
            drive.lo <= 1'b0;
        end else if (dcnt != '0) begin
            dcnt <= dcnt - ONE;
            if (dcnt == ONE) begin
                drive.hi <= sel_top;
                drive.lo <= ~sel_top;
            end
        end
    end
endmodule

// File: rtl/hbg_phase_gate.sv
// hbg_phase_gate: top of the phase-shifted H-bridge gate generator.
// The right leg flips on each period wrap, the left leg on each compare
// match; the compare offset sets the phase between legs.
// Assumes dead time is shorter than one counter period.
module hbg_phase_gate
    import hbg_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  period_in,
    input  logic [CNT_W-1:0]  compare_in,
    input  logic [DEAD_W-1:0] dead_in,
    output logic              gate_tl,
    output logic              gate_bl,
    output logic              gate_tr,
    output logic              gate_br
);
    logic              per_hit;
    logic              cmp_hit;
    logic [DEAD_W-1:0] dead_q;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  per_w;
    logic [NUM_LEGS-1:0] leg_evt;
    leg_drive_t        leg_drv [NUM_LEGS];

    hbg_timebase #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .period_in (period_in),
        .compare_in(compare_in),
        .dead_in   (dead_in),
        .per_hit   (per_hit),
        .cmp_hit   (cmp_hit),
        .dead_q    (dead_q),
        .cnt       (cnt_w),
        .per_q     (per_w)
    );

    assign leg_evt[LEG_RIGHT] = per_hit;
    assign leg_evt[LEG_LEFT]  = cmp_hit;

    // One sequencer per leg; right starts on bottom, left on top.
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbg_leg #(
            .DEAD_W   (DEAD_W),
            .FIRST_TOP(g == LEG_LEFT)
        ) u_leg (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (enable),
            .evt  (leg_evt[g]),
            .dead (dead_q),
            .drive(leg_drv[g])
        );
    end

    assign gate_tl = leg_drv[LEG_LEFT].hi;
    assign gate_bl = leg_drv[LEG_LEFT].lo;
    assign gate_tr = leg_drv[LEG_RIGHT].hi;
    assign gate_br = leg_drv[LEG_RIGHT].lo;
endmodule

// File: rtl/hbg_phase_gate_chk.sv
// hbg_phase_gate_chk: cycle-by-cycle properties of the gate generator,
// bound into every instance of hbg_phase_gate.
module hbg_phase_gate_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             gate_tl,
    input logic             gate_bl,
    input logic             gate_tr,
    input logic             gate_br,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_q
);
    p_left_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_tl && gate_bl));

    p_right_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_tr && gate_br));

    p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(gate_tl || gate_bl || gate_tr || gate_br));

    p_gap_tl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_tl) |-> !$past(gate_bl));

    p_gap_bl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_bl) |-> !$past(gate_tl));

    p_gap_tr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_tr) |-> !$past(gate_br));

    p_gap_br_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_br) |-> !$past(gate_tr));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_q);
endmodule

bind hbg_phase_gate hbg_phase_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .gate_tl(gate_tl),
    .gate_bl(gate_bl),
    .gate_tr(gate_tr),
    .gate_br(gate_br),
    .cnt    (cnt_w),
    .per_q  (per_w)
);

// File: tb/hbg_phase_gate_test.sv
// Bench for hbg_phase_gate: a requirement-level reference model compared
// every cycle, plus waveform measurements on directed and random cases.
module hbg_phase_gate_test;
    localparam int CW = 12;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] period_in = '0;
    logic [CW-1:0] compare_in = '0;
    logic [DW-1:0] dead_in = '0;
    logic gate_tl, gate_bl, gate_tr, gate_br;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    string cur_req = "R3";
    bit model_on = 1'b0;
    bit inph_on = 1'b0;

    always #2 clk = ~clk;

    hbg_phase_gate #(.CNT_W(CW), .DEAD_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .period_in(period_in), .compare_in(compare_in), .dead_in(dead_in),
        .gate_tl(gate_tl), .gate_bl(gate_bl), .gate_tr(gate_tr), .gate_br(gate_br)
    );

    // Reference model state (index 0 = right leg, 1 = left leg).
    int m_cnt, m_per, m_cmp, m_dt;
    int m_dc [2];
    bit m_sel [2];
    bit m_hi [2];
    bit m_lo [2];

    function automatic int clamp_cmp(int c, int p);
        return (c > p) ? p : c;
    endfunction

    function automatic int eff_dead(int d);
        return (d == 0) ? 1 : d;
    endfunction

    // Model: counts 0..P, right leg flips at P, left at clamped compare.
    always @(posedge clk) begin
        bit ev [2];
        if (!rst_n || !enable) begin
            m_cnt <= 0;
            m_per <= rst_n ? int'(period_in) : 0;
            m_cmp <= rst_n ? clamp_cmp(int'(compare_in), int'(period_in)) : 0;
            m_dt  <= rst_n ? eff_dead(int'(dead_in)) : 1;
            for (int i = 0; i < 2; i++) begin
                m_sel[i] <= (i == 1) ? 1'b0 : 1'b1;
                m_dc[i]  <= 0;
                m_hi[i]  <= 1'b0;
                m_lo[i]  <= 1'b0;
            end
        end else begin
            ev[0] = (m_cnt == m_per);
            ev[1] = (m_cnt == m_cmp);
            if (ev[0]) begin
                m_cnt <= 0;
                m_per <= int'(period_in);
                m_cmp <= clamp_cmp(int'(compare_in), int'(period_in));
                m_dt  <= eff_dead(int'(dead_in));
            end else begin
                m_cnt <= m_cnt + 1;
            end
            for (int i = 0; i < 2; i++) begin
                if (ev[i]) begin
                    m_sel[i] <= ~m_sel[i];
                    m_dc[i]  <= m_dt;
                    m_hi[i]  <= 1'b0;
                    m_lo[i]  <= 1'b0;
                end else if (m_dc[i] != 0) begin
                    m_dc[i] <= m_dc[i] - 1;
                    if (m_dc[i] == 1) begin
                        m_hi[i] <= m_sel[i];
                        m_lo[i] <= ~m_sel[i];
                    end
                end
            end
        end
    end

    // Waveform measurement on the right leg, sampled at negedge.
    int cyc = 0;
    int last_rise = -1;
    int per_meas = -1, hi3_meas = -1, hi4_meas = -1, gap_meas = -1;
    int hi3_run = 0, hi4_run = 0, gap_run = 0;
    bit prev3 = 1'b0, prev4 = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (gate_br && !prev4) begin
            if (last_rise >= 0) per_meas = cyc - last_rise;
            last_rise = cyc;
            if (hi3_run == 0 && prev3 == 1'b0) gap_meas = gap_run;
        end
        if (gate_tr && !prev3) gap_meas = gap_run;
        if (!gate_br && prev4) hi4_meas = hi4_run;
        if (!gate_tr && prev3) hi3_meas = hi3_run;
        hi4_run = gate_br ? hi4_run + 1 : 0;
        hi3_run = gate_tr ? hi3_run + 1 : 0;
        gap_run = (!gate_tr && !gate_br) ? gap_run + 1 : 0;
        prev3 = gate_tr;
        prev4 = gate_br;
    end

    // Per-cycle comparison against the model and the leg exclusion rule.
    always @(negedge clk) begin
        if (model_on && !done) begin
            nchk++;
            if ({gate_tr, gate_br} != {m_hi[0], m_lo[0]}) begin
                nfail++;
                $display("FAIL R3 (%s): right leg tr/br=%b%b expected %b%b at cyc %0d",
                         cur_req, gate_tr, gate_br, m_hi[0], m_lo[0], cyc);
            end
            nchk++;
            if ({gate_tl, gate_bl} != {m_hi[1], m_lo[1]}) begin
                nfail++;
                $display("FAIL R4 (%s): left leg tl/bl=%b%b expected %b%b at cyc %0d",
                         cur_req, gate_tl, gate_bl, m_hi[1], m_lo[1], cyc);
            end
            nchk++;
            if ((gate_tl && gate_bl) || (gate_tr && gate_br)) begin
                nfail++;
                $display("FAIL R10: gates tl bl tr br=%b%b%b%b expected no leg both on",
                         gate_tl, gate_bl, gate_tr, gate_br);
            end
            if (inph_on) begin
                nchk++;
                if (gate_tl != gate_br || gate_bl != gate_tr) begin
                    nfail++;
                    $display("FAIL %s: tl/br=%b%b bl/tr=%b%b expected equal pairs",
                             cur_req, gate_tl, gate_br, gate_bl, gate_tr);
                end
            end
        end
    end

    task automatic check_int(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_off(string req);
        nchk++;
        if ({gate_tl, gate_bl, gate_tr, gate_br} != 4'b0000) begin
            nfail++;
            $display("FAIL %s: gates=%b expected 0000", req,
                     {gate_tl, gate_bl, gate_tr, gate_br});
        end
    endtask

    // One scenario: idle check, run, optional mid-run period change, measure.
    task automatic run_case(int p, int c, int d, int p2, int chg_at,
                            string req, bit inph);
        int n;
        int pf;
        @(negedge clk);
        enable     = 1'b0;
        period_in  = CW'(p);
        compare_in = CW'(c);
        dead_in    = DW'(d);
        @(negedge clk);
        check_off("R1");
        last_rise = -1; per_meas = -1; hi3_meas = -1; hi4_meas = -1; gap_meas = -1;
        cur_req = req;
        inph_on = inph;
        enable  = 1'b1;
        pf = (chg_at > 0) ? p2 : p;
        n = 6 * (p + 1) + 6 * (pf + 1) + 10;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (chg_at > 0 && k == chg_at) period_in = CW'(p2);
        end
        #1;
        inph_on = 1'b0;
        check_int({"R2 period ", req}, per_meas, 2 * (pf + 1));
        check_int({"R7 dead gap ", req}, gap_meas, eff_dead(d));
        check_int({"R8 top width ", req}, hi3_meas, pf + 1 - eff_dead(d));
        check_int({"R8 bottom width ", req}, hi4_meas, pf + 1 - eff_dead(d));
    endtask

    initial begin
        int seed_d;
        seed_d = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        check_off("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;

        // Full load: compare equals period, legs in phase.
        run_case(30, 30, 1, 0, 0, "R5", 1'b1);
        // Oversized compare clamps to period.
        run_case(20, 40, 2, 0, 0, "R6", 1'b1);
        // Zero dead time acts as one cycle; compare at count 0.
        run_case(16, 0, 0, 0, 0, "R7", 1'b0);
        // Period change mid-cycle only takes effect at the wrap.
        run_case(25, 10, 3, 12, 9, "R9", 1'b0);
        run_case(12, 5, 4, 40, 30, "R9", 1'b0);

        // Disable mid-run clears all gates on the next edge.
        @(negedge clk);
        period_in = CW'(10); compare_in = CW'(4); dead_in = DW'(1);
        enable = 1'b1;
        repeat (37) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check_off("R1 disable");

        // Random phase, period and dead time.
        for (int s = 0; s < 16; s++) begin
            int p, c, d;
            p = 8 + int'($urandom % 53);
            c = int'($urandom % (p + 12));
            d = int'($urandom % 6);
            run_case(p, c, d, 0, 0, "R4 random", c >= p);
        end

        // Reset while running clears all gates.
        @(negedge clk);
        enable = 1'b1;
        repeat (20) @(negedge clk);
        model_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check_off("R1 reset while running");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule